// File: doc/BRIEF.md
# Frame highlight statistics unit

The unit measures a frame of 24-bit RGB pixels in two passes and produces the three 8-bit constants a highlight-correction datapath needs. The same frame is streamed to it twice. During the first scan it averages the smallest colour channel of every pixel. During the second scan it uses that average to sort each pixel into a highlight set or a non-highlight set. For each set it accumulates moments of the minimum channel and of the gray level. A shared sequential divider and an integer square-root unit then turn these moments into means and standard deviations.

Two offsets come out of the second scan. The colour offset is the non-highlight mean of the minimum channel plus its standard deviation. The brightness offset is the smaller of the two sets' gray-level standard deviations. The frame store sits outside the unit. It starts a run with `start`, streams pixels while `accept` is high, and uses `second_pass` to tell which scan is open. It ends each scan with `pix_last`. A one-cycle `done` pulse publishes the results.

The controller has eight states:
- IDLE: `start` leads to SCAN1.
- SCAN1: an accepted pixel carrying `pix_last` leads to AVG.
- AVG: divider done leads to SCAN2.
- SCAN2: an accepted pixel carrying `pix_last` leads to MEAN.
- MEAN: divider done leads to ROOT, for job 0.
- ROOT: root done leads to SDIV.
- SDIV: divider done leads back to ROOT for the next job, or to FIN after job 2. The three jobs are the non-highlight minimum channel, the non-highlight gray level and the highlight gray level.
- FIN: leads to IDLE in one cycle.

Top module: `hl_frame_stats`

## Requirements
- R1: The pixel packs red in bits 23:16, green in 15:8 and blue in 7:0. At the end of scan one, the frame average of m = min(R,G,B) is held as A = floor((2·S + N) / (2·N)). Here S is the sum of m and N the pixel count. A appears on `min_avg` at `done`.
- R2: In scan two a pixel is in the highlight set exactly when m > 2·A. Every other pixel is in the non-highlight set.
- R3: `cmsf` = min(255, mean + sd), where both are taken over the minimum channel of the non-highlight set. The mean is floor((2·S1 + n) / (2·n)).
- R4: The standard deviation of a set of n values with sum S1 and sum of squares S2 is floor((2·q + n) / (2·n)). Here q = floor(sqrt(n·S2 − S1²)).
- R5: The gray level is (77·R + 150·G + 29·B + 128) >> 8.
- R6: `bright_ofs` = min(gray sd of the non-highlight set, gray sd of the highlight set).
- R7: The mean and standard deviation of an empty set are 0. A frame with no highlight pixel therefore gives `bright_ofs` = 0.
- R8: `accept` is high only during the two scans, and `second_pass` is high only during scan two. A scan ends at the accepted pixel that carries `pix_last`. `start` acts only in IDLE.
- R9: `done` is a one-cycle pulse after the second scan's arithmetic has finished. The three result outputs change only in the cycle `done` is high and hold otherwise.
- R10: After reset all outputs are 0. Pixels presented while the unit is idle are ignored and affect neither the outputs nor the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (IDLE only) |
| pix_valid | input | 1 | Pixel present on pix_rgb |
| pix_last | input | 1 | Pixel is the final one of the scan |
| pix_rgb | input | 24 | Pixel, R[23:16] G[15:8] B[7:0] |
| accept | output | 1 | A scan is open; valid pixels are consumed |
| second_pass | output | 1 | The open scan is scan two |
| done | output | 1 | One-cycle result pulse |
| min_avg | output | 8 | Frame average of the minimum channel |
| cmsf | output | 8 | Colour offset for highlight pixels |
| bright_ofs | output | 8 | Brightness offset |

## Verification
The bench builds the unit with the default count width of 20 bits. This sizes the moment accumulators and the 56-bit radicand for frames of a million pixels, while short frames keep every run brief. It uses that width to push the extreme cases through the full-width divider and root datapath: a single pixel, all-black and all-white frames, and a two-pixel frame whose colour offset saturates at 255. A mixed frame with gaps in `pix_valid` and random frames exercise both sets. Pixels driven during IDLE test that input is ignored.

// File: rtl/hl_stats_pkg.sv
`timescale 1ns/1ps
package hl_stats_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN1,
        ST_AVG,
        ST_SCAN2,
        ST_MEAN,
        ST_ROOT,
        ST_SDIV,
        ST_FIN
    } hl_state_t;

    function automatic logic [7:0] min3(input logic [23:0] p);
        logic [7:0] a;
        a = (p[23:16] < p[15:8]) ? p[23:16] : p[15:8];
        return (a < p[7:0]) ? a : p[7:0];
    endfunction

    function automatic logic [7:0] gray8(input logic [23:0] p);
        logic [15:0] acc;
        acc = 16'(77) * 16'(p[23:16]) + 16'(150) * 16'(p[15:8])
            + 16'(29) * 16'(p[7:0]) + 16'd128;
        return acc[15:8];
    endfunction

endpackage

// File: rtl/hl_moment.sv
`timescale 1ns/1ps
module hl_moment #(
    parameter int CNT_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [7:0]           x,
    output logic [CNT_W+7:0]     s1,
    output logic [CNT_W+15:0]    s2
);
    localparam int S1W = CNT_W + 8;
    localparam int S2W = CNT_W + 16;

    logic [15:0] sq;
    assign sq = 16'(x) * 16'(x);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s1 <= '0;
            s2 <= '0;
        end else if (en) begin
            s1 <= s1 + S1W'(x);
            s2 <= s2 + S2W'(sq);
        end
    end
endmodule

// File: rtl/hl_divider.sv
`timescale 1ns/1ps
module hl_divider #(
    parameter int NW = 30,
    parameter int DW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem;
    logic [DW:0]   rem_sh;
    logic [CW-1:0] cnt;
    logic          busy;

    assign rem_sh = {rem, quo[NW-1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            quo  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= busy && (cnt == CW'(1));
            if (go) begin
                rem  <= '0;
                quo  <= num;
                cnt  <= CW'(NW);
                busy <= 1'b1;
            end else if (busy) begin
                if (rem_sh >= {1'b0, den}) begin
                    rem <= DW'(rem_sh - {1'b0, den});
                    quo <= {quo[NW-2:0], 1'b1};
                end else begin
                    rem <= rem_sh[DW-1:0];
                    quo <= {quo[NW-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hl_isqrt.sv
`timescale 1ns/1ps
module hl_isqrt #(
    parameter int RW = 56
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [RW-1:0]   rad_in,
    output logic            done,
    output logic [RW/2-1:0] root
);
    localparam int HW = RW / 2;
    localparam int CW = $clog2(HW + 1);

    logic [RW-1:0] rad;
    logic [HW:0]   rem;
    logic [HW+2:0] rem_n;
    logic [HW+2:0] trial;
    logic [CW-1:0] cnt;
    logic          busy;

    assign rem_n = {rem, rad[RW-1:RW-2]};
    assign trial = {(HW+1)'(root), 2'b01};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad  <= '0;
            rem  <= '0;
            root <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= busy && (cnt == CW'(1));
            if (go) begin
                rad  <= rad_in;
                rem  <= '0;
                root <= '0;
                cnt  <= CW'(HW);
                busy <= 1'b1;
            end else if (busy) begin
                if (rem_n >= trial) begin
                    rem  <= rem_n[HW:0] - trial[HW:0];
                    root <= {root[HW-2:0], 1'b1};
                end else begin
                    rem  <= rem_n[HW:0];
                    root <= {root[HW-2:0], 1'b0};
                end
                rad <= {rad[RW-3:0], 2'b00};
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hl_frame_stats.sv
`timescale 1ns/1ps
module hl_frame_stats
    import hl_stats_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        pix_valid,
    input  logic        pix_last,
    input  logic [23:0] pix_rgb,
    output logic        accept,
    output logic        second_pass,
    output logic        done,
    output logic [7:0]  min_avg,
    output logic [7:0]  cmsf,
    output logic [7:0]  bright_ofs
);
    localparam int S1W  = CNT_W + 8;
    localparam int S2W  = CNT_W + 16;
    localparam int VW   = 2 * CNT_W + 16;
    localparam int RTW  = VW / 2;
    localparam int NW   = CNT_W + 10;
    localparam int DW   = CNT_W + 1;
    localparam int NMOM = 3;

    hl_state_t state, nxt;

    logic [CNT_W-1:0] cnt_nh, cnt_h, cnt_sel;
    logic [7:0]       avg_r, mean_nh;
    logic [7:0]       sd_r [NMOM];
    logic [1:0]       job;
    logic             armed;
    logic [RTW-1:0]   root_r;

    logic [7:0]       pm, pg;
    logic             take, is_hl, clr;
    logic [S1W-1:0]   s1 [NMOM];
    logic [S2W-1:0]   s2 [NMOM];
    logic [VW-1:0]    var_v;

    logic             go_div, go_sq, div_done, sq_done;
    logic [NW-1:0]    d_num, quo;
    logic [DW-1:0]    d_den;
    logic [RTW-1:0]   sq_root;
    logic [8:0]       cm_sum;

    function automatic logic [7:0] sat8(input logic [NW-1:0] v);
        return (v > NW'(255)) ? 8'hFF : v[7:0];
    endfunction

    assign accept      = (state == ST_SCAN1) || (state == ST_SCAN2);
    assign second_pass = (state == ST_SCAN2);
    assign take        = accept && pix_valid;
    assign pm          = min3(pix_rgb);
    assign pg          = gray8(pix_rgb);
    assign is_hl       = second_pass && ({1'b0, pm} > {avg_r, 1'b0});
    assign clr         = ((state == ST_IDLE) && start) || ((state == ST_AVG) && div_done);

    generate
        for (genvar k = 0; k < NMOM; k++) begin : g_mom
            localparam bit HL_SET  = (k == 2);
            localparam bit MIN_VAL = (k == 0);
            hl_moment #(.CNT_W(CNT_W)) u_mom (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (clr),
                .en   (take && (is_hl == HL_SET)),
                .x    (MIN_VAL ? pm : pg),
                .s1   (s1[k]),
                .s2   (s2[k])
            );
        end
    endgenerate

    assign cnt_sel = (job == 2'd2) ? cnt_h : cnt_nh;
    assign var_v   = VW'(cnt_sel) * VW'(s2[job]) - VW'(s1[job]) * VW'(s1[job]);

    assign go_div = ((state == ST_AVG) || (state == ST_MEAN) || (state == ST_SDIV)) && !armed;
    assign go_sq  = (state == ST_ROOT) && !armed;

    always_comb begin
        if (state == ST_SDIV) begin
            d_num = (NW'(root_r) << 1) + NW'(cnt_sel);
            d_den = {cnt_sel, 1'b0};
        end else begin
            d_num = (NW'(s1[0]) << 1) + NW'(cnt_nh);
            d_den = {cnt_nh, 1'b0};
        end
    end

    hl_divider #(.NW(NW), .DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(go_div), .num(d_num), .den(d_den),
        .done(div_done), .quo(quo)
    );

    hl_isqrt #(.RW(VW)) u_sqrt (
        .clk(clk), .rst_n(rst_n), .go(go_sq), .rad_in(var_v),
        .done(sq_done), .root(sq_root)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)             nxt = ST_SCAN1;
            ST_SCAN1: if (take && pix_last)  nxt = ST_AVG;
            ST_AVG:   if (div_done)          nxt = ST_SCAN2;
            ST_SCAN2: if (take && pix_last)  nxt = ST_MEAN;
            ST_MEAN:  if (div_done)          nxt = ST_ROOT;
            ST_ROOT:  if (sq_done)           nxt = ST_SDIV;
            ST_SDIV:  if (div_done)          nxt = (job == 2'd2) ? ST_FIN : ST_ROOT;
            ST_FIN:                          nxt = ST_IDLE;
            default:                         nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign cm_sum = {1'b0, mean_nh} + {1'b0, sd_r[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_nh     <= '0;
            cnt_h      <= '0;
            avg_r      <= '0;
            mean_nh    <= '0;
            root_r     <= '0;
            job        <= '0;
            armed      <= 1'b0;
            done       <= 1'b0;
            min_avg    <= '0;
            cmsf       <= '0;
            bright_ofs <= '0;
            for (int k = 0; k < NMOM; k++) sd_r[k] <= '0;
        end else begin
            done <= 1'b0;
            if (go_div || go_sq)        armed <= 1'b1;
            else if (div_done || sq_done) armed <= 1'b0;

            if (clr) begin
                cnt_nh <= '0;
                cnt_h  <= '0;
            end else if (take) begin
                if (is_hl) cnt_h  <= cnt_h + CNT_W'(1);
                else       cnt_nh <= cnt_nh + CNT_W'(1);
            end

            unique case (state)
                ST_IDLE: if (start) job <= '0;
                ST_AVG:  if (div_done) avg_r <= (cnt_nh == '0) ? 8'd0 : sat8(quo);
                ST_MEAN: if (div_done) mean_nh <= (cnt_nh == '0) ? 8'd0 : sat8(quo);
                ST_ROOT: if (sq_done) root_r <= sq_root;
                ST_SDIV: if (div_done) begin
                    sd_r[job] <= (cnt_sel == '0) ? 8'd0 : sat8(quo);
                    job       <= job + 2'd1;
                end
                ST_FIN: begin
                    done       <= 1'b1;
                    min_avg    <= avg_r;
                    cmsf       <= cm_sum[8] ? 8'hFF : cm_sum[7:0];
                    bright_ofs <= (sd_r[1] < sd_r[2]) ? sd_r[1] : sd_r[2];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hl_stats_chk.sv
`timescale 1ns/1ps
module hl_stats_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       accept,
    input logic       second_pass,
    input logic       done,
    input logic [7:0] min_avg,
    input logic [7:0] cmsf,
    input logic [7:0] bright_ofs
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({min_avg, cmsf, bright_ofs})); // R9

    AST_PASS_INSIDE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        second_pass |-> accept); // R8

    AST_NO_ACCEPT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !accept); // R10

    AST_NO_DONE_AFTER_SCAN1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !second_pass) |=> !done); // R8

    AST_BO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bright_ofs <= 8'd128); // R6
endmodule

bind hl_frame_stats hl_stats_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .second_pass(second_pass),
    .done       (done),
    .min_avg    (min_avg),
    .cmsf       (cmsf),
    .bright_ofs (bright_ofs)
);

// File: tb/hl_frame_stats_test.sv
`timescale 1ns/1ps
module hl_frame_stats_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, pix_valid = 1'b0, pix_last = 1'b0;
    logic [23:0] pix_rgb = '0;
    logic accept, second_pass, done;
    logic [7:0] min_avg, cmsf, bright_ofs;

    int checks = 0, errors = 0;
    int cyc = 0;
    bit pending = 0, live = 0;
    int exp_avg, exp_cm, exp_bo, pub_avg = 0, pub_cm = 0, pub_bo = 0;
    logic [23:0] frame [$];

    always #2 clk = ~clk;

    hl_frame_stats uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
        .pix_last(pix_last), .pix_rgb(pix_rgb), .accept(accept),
        .second_pass(second_pass), .done(done), .min_avg(min_avg),
        .cmsf(cmsf), .bright_ofs(bright_ofs)
    );

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic longint isq(input longint v);
        longint r = 0;
        for (longint b = 64'd1 << 30; b > 0; b >>= 1)
            if ((r + b) * (r + b) <= v) r += b;
        return r;
    endfunction

    function automatic int sdev(input longint n, input longint s1, input longint s2);
        if (n == 0) return 0;
        return int'((2 * isq(n * s2 - s1 * s1) + n) / (2 * n));
    endfunction

    function automatic int mn(input logic [23:0] p);
        int a = p[23:16];
        if (p[15:8] < a) a = p[15:8];
        if (p[7:0] < a) a = p[7:0];
        return a;
    endfunction

    function automatic int gy(input logic [23:0] p);
        return (77 * p[23:16] + 150 * p[15:8] + 29 * p[7:0] + 128) >> 8;
    endfunction

    task automatic model();
        longint n = frame.size(), s = 0;
        longint nn = 0, nh = 0, m1 = 0, m2 = 0, g1 = 0, g2 = 0, h1 = 0, h2 = 0;
        int mean, sdm, sdg, sdh;
        foreach (frame[i]) s += mn(frame[i]);
        exp_avg = int'((2 * s + n) / (2 * n));
        foreach (frame[i]) begin
            int m = mn(frame[i]), g = gy(frame[i]);
            if (m > 2 * exp_avg) begin
                nh++; h1 += g; h2 += g * g;
            end else begin
                nn++; m1 += m; m2 += m * m; g1 += g; g2 += g * g;
            end
        end
        mean = (nn == 0) ? 0 : int'((2 * m1 + nn) / (2 * nn));
        sdm  = sdev(nn, m1, m2);
        sdg  = sdev(nn, g1, g2);
        sdh  = sdev(nh, h1, h2);
        exp_cm = (mean + sdm > 255) ? 255 : mean + sdm;
        exp_bo = (sdg < sdh) ? sdg : sdh;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (live) begin
            if (done) begin
                checks++;
                if (!pending) begin
                    errors++;
                    $display("FAIL R9 unexpected done actual=1 expected=0");
                end
                pending = 0;
                pub_avg = exp_avg; pub_cm = exp_cm; pub_bo = exp_bo;
            end
            check("R9 min_avg hold/update", min_avg, pub_avg);
            check("R9 cmsf hold/update", cmsf, pub_cm);
            check("R9 bright_ofs hold/update", bright_ofs, pub_bo);
        end
    end

    task automatic scan(input bit two, input bit gaps);
        int i = 0, guard = 0;
        while (!(accept && second_pass == two) && guard < 2000) begin
            @(negedge clk); guard++;
        end
        check("R8 scan open with right pass flag", int'(accept && second_pass == two), 1);
        while (i < frame.size()) begin
            if (gaps && (i % 4 == 1) && !pix_valid) begin
                pix_valid = 0;
                @(negedge clk);
                pix_valid = 1;
            end
            pix_valid = 1;
            pix_rgb   = frame[i];
            pix_last  = (i == frame.size() - 1);
            check("R8 accept high during scan", int'(accept), 1);
            i++;
            @(negedge clk);
            pix_valid = 0;
        end
        pix_last = 0;
        check("R8 scan closed after last pixel", int'(accept && second_pass == two), 0);
    endtask

    task automatic run(input string name, input bit gaps);
        int guard = 0;
        model();
        pending = 1;
        start = 1;
        @(negedge clk);
        start = 0;
        scan(0, gaps);
        scan(1, gaps);
        while (pending && guard < 5000) begin
            @(negedge clk); guard++;
        end
        check({"R9 done reached ", name}, int'(pending), 0);
        check({"R1 min_avg ", name}, min_avg, exp_avg);
        check({"R2 R3 R4 cmsf ", name}, cmsf, exp_cm);
        check({"R5 R6 R7 bright_ofs ", name}, bright_ofs, exp_bo);
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 reset min_avg", min_avg, 0);
        check("R10 reset cmsf", cmsf, 0);
        check("R10 reset bright_ofs", bright_ofs, 0);
        check("R10 reset done", done, 0);
        check("R8 reset accept", accept, 0);
        live = 1;

        frame = {24'h0A325A};
        run("single pixel", 0);

        frame = {};
        for (int i = 0; i < 16; i++) frame.push_back(24'h000000);
        run("all black", 0);

        frame = {};
        for (int i = 0; i < 40; i++)
            frame.push_back({8'($urandom_range(0, 40)), 8'($urandom_range(0, 40)), 8'($urandom_range(0, 40))});
        for (int i = 0; i < 10; i++)
            frame.push_back({8'($urandom_range(200, 255)), 8'($urandom_range(210, 255)), 8'($urandom_range(220, 255))});
        run("mixed with highlights", 1);

        frame = {};
        for (int i = 0; i < 8; i++) frame.push_back(24'hFFFFFF);
        run("all white", 0);

        frame = {24'hFFFFFF, 24'h000000};
        run("saturating cmsf", 0);

        for (int f = 0; f < 3; f++) begin
            frame = {};
            for (int i = 0; i < 300; i++) frame.push_back(24'($urandom));
            run("random", f[0]);
        end

        // R10: pixels while idle are ignored
        for (int i = 0; i < 20; i++) begin
            pix_valid = 1; pix_last = (i % 3 == 0); pix_rgb = 24'hFF00FF;
            @(negedge clk);
            check("R10 idle ignores pixels (accept)", accept, 0);
            check("R10 idle ignores pixels (done)", done, 0);
        end
        pix_valid = 0; pix_last = 0;
        frame = {24'h102030, 24'h405060, 24'hF0F0F0, 24'h203040, 24'h304050};
        run("after idle pixels", 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule